// File: doc/BRIEF.md
# Synchronous Pipelined SRAM Core

This block is a synthesizable single-port synchronous SRAM. Its depth and its word width are parameters. Address, write data, chip enable and all write controls are captured on the rising clock edge. The caller supplies a final word address, so there is no burst counter in the block. A static strap, `pipe_mode`, picks the read path. With the strap low, array data reaches the output in the same cycle the address register updates (flow-through). With the strap high, the data passes through one more output register (pipelined). A new command may be issued on every clock edge.

The output stage follows a dual-cycle deselect rule: the driver-enable state moves down the same pipeline as read data. After an idle edge, the bus therefore stays driven for one more cycle with the last read word. The output enable and the sleep input act on the driver without waiting for a clock. Sleep also blocks every command, and it leaves the array contents untouched. The data bus is modelled as a separate output `dout` with an enable `dout_en`, so a high-impedance pad driver can be attached outside the block.

Writes are controlled per 9-bit lane. Lane i covers bits 9i+8 down to 9i. A global write stores the whole word, whatever the lane controls say.

Top module: `sram_sync_core`

## Requirements
- R1: While `rst_n` is low and after it is released, `dout_en` is low until a read has been sampled.
- R2: With `pipe_mode`=0, a read sampled at edge N drives `dout_en`=1 and the word at that address on `dout` after edge N.
- R3: With `pipe_mode`=1, a read sampled at edge N that follows an idle edge leaves `dout_en` low after edge N. It drives the stored word with `dout_en`=1 after edge N+1.
- R4: When a read is followed by an idle edge D, the bus remains driven with the same read word after edge D and goes off after edge D+1. This holds in both modes. An idle edge has `ce`=0.
- R5: Reads sampled on consecutive edges return one new word per cycle, in issue order, with no gap.
- R6: A write with `byte_wr`=1 stores lane i only where `byte_en[i]`=1. The other lanes keep their previous contents.
- R7: A command with `ce`=1, `byte_wr`=1, all `byte_en` low and `glob_wr`=0 is a read, and it changes no stored data.
- R8: `glob_wr`=1 with `ce`=1 stores every lane, whatever the values of `byte_wr` and `byte_en`.
- R9: `oe`=0 forces `dout_en` low at once, without a clock edge. Raising `oe` again restores the driven state.
- R10: After an edge that samples a write, `dout_en` is low for the following cycle.
- R11: `sleep`=1 forces `dout_en` low at once. Commands sampled while it is high neither write nor read. Stored data survives sleep, and the first edge after release accepts a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state; the array is not cleared |
| pipe_mode | input | 1 | Static strap: 0 flow-through, 1 pipelined |
| ce | input | 1 | Chip enable; 0 makes the edge an idle (deselect) edge |
| addr | input | $clog2(DEPTH) | Word address |
| din | input | WIDTH | Write data |
| byte_en | input | WIDTH/9 | Per-lane write enables |
| byte_wr | input | 1 | Lane write mode |
| glob_wr | input | 1 | Whole-word write, overrides lane controls |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request; commands are ignored |
| dout | output | WIDTH | Read data |
| dout_en | output | 1 | Output driver enable |

## Verification
Single reads are issued in each mode after an idle edge. Sampling one and two edges after the read separates the flow-through latency from the pipelined latency, and the samples that follow show when the deselect pipeline switches the driver off. Back-to-back reads of distinct addresses show that every cycle returns a new word, and that the words come back in order. Lane writes with one enable, a lane write with no enable, and global writes over mixed lane controls tell partial-write masking apart from override behaviour. The asynchronous `oe` and `sleep` inputs are toggled between edges to show that they act without a clock. A write and a read issued during sleep show that neither has any effect.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode #(
    parameter int NB = 4
) (
    input  logic          ce,
    input  logic          sleep,
    input  logic [NB-1:0] byte_en,
    input  logic          byte_wr,
    input  logic          glob_wr,
    output sram_pkg::op_e op,
    output logic [NB-1:0] lane_we
);
    logic [NB-1:0] mask;

    always_comb begin
        // whole-word write wins over the lane controls
        if (glob_wr)      mask = '1;
        else if (byte_wr) mask = byte_en;
        else              mask = '0;

        if (!ce || sleep)  op = sram_pkg::OP_IDLE;
        else if (|mask)    op = sram_pkg::OP_WRITE;
        else               op = sram_pkg::OP_READ;

        lane_we = (op == sram_pkg::OP_WRITE) ? mask : '0;
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sram_pkg::op_e op,
    input  logic [AW-1:0] addr,
    output logic          rd_s1,
    output logic          rd_s2,
    output logic          wr_s1,
    output logic [AW-1:0] raddr
);
    typedef struct packed {
        logic          rd1;
        logic          rd2;
        logic          wr1;
        logic [AW-1:0] adr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rd1 = (op == sram_pkg::OP_READ);
        st_d.wr1 = (op == sram_pkg::OP_WRITE);
        // the driver state moves one stage further, like read data
        st_d.rd2 = st_q.rd1;
        if (op == sram_pkg::OP_READ) st_d.adr = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_s1 = st_q.rd1;
    assign rd_s2 = st_q.rd2;
    assign wr_s1 = st_q.wr1;
    assign raddr = st_q.adr;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int DEPTH = 64,
    parameter int NB    = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int W    = NB * sram_pkg::LANE_W
) (
    input  logic          clk,
    input  logic [NB-1:0] lane_we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int LW = sram_pkg::LANE_W;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) mem_q[waddr] <= wdata[g*LW +: LW];
        end

        assign rdata[g*LW +: LW] = mem_q[raddr];
    end
endmodule

// File: rtl/sram_outpath.sv
module sram_outpath #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pipe_mode,
    input  logic         oe,
    input  logic         sleep,
    input  logic         rd_s1,
    input  logic         rd_s2,
    input  logic         wr_s1,
    input  logic [W-1:0] arr_rd,
    output logic [W-1:0] dout,
    output logic         dout_en
);
    typedef struct packed {
        logic [W-1:0] data;
    } out_t;

    out_t st_d, st_q;
    logic stage_on;

    always_comb begin
        st_d = st_q;
        if (rd_s1) st_d.data = arr_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (pipe_mode) begin
            stage_on = rd_s2;
            dout     = st_q.data;
        end else begin
            stage_on = rd_s1 | rd_s2;
            dout     = rd_s1 ? arr_rd : st_q.data;
        end
        dout_en = stage_on & oe & ~sleep & ~wr_s1;
    end
endmodule

// File: rtl/sram_sync_core.sv
module sram_sync_core #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 36,
    localparam int NB   = WIDTH / sram_pkg::LANE_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pipe_mode,
    input  logic             ce,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    input  logic [NB-1:0]    byte_en,
    input  logic             byte_wr,
    input  logic             glob_wr,
    input  logic             oe,
    input  logic             sleep,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en
);
    sram_pkg::op_e    op;
    logic [NB-1:0]    lane_we;
    logic             rd_s1, rd_s2, wr_s1;
    logic [AW-1:0]    raddr;
    logic [WIDTH-1:0] arr_rd;

    sram_cmd_decode #(.NB(NB)) u_dec (
        .ce(ce), .sleep(sleep), .byte_en(byte_en), .byte_wr(byte_wr),
        .glob_wr(glob_wr), .op(op), .lane_we(lane_we)
    );

    sram_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op), .addr(addr),
        .rd_s1(rd_s1), .rd_s2(rd_s2), .wr_s1(wr_s1), .raddr(raddr)
    );

    sram_array #(.DEPTH(DEPTH), .NB(NB)) u_arr (
        .clk(clk), .lane_we(lane_we), .waddr(addr), .wdata(din),
        .raddr(raddr), .rdata(arr_rd)
    );

    sram_outpath #(.W(WIDTH)) u_out (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe(oe),
        .sleep(sleep), .rd_s1(rd_s1), .rd_s2(rd_s2), .wr_s1(wr_s1),
        .arr_rd(arr_rd), .dout(dout), .dout_en(dout_en)
    );
endmodule

// File: rtl/sram_sync_core_chk.sv
module sram_sync_core_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pipe_mode,
    input logic          ce,
    input logic [NB-1:0] byte_en,
    input logic          byte_wr,
    input logic          glob_wr,
    input logic          oe,
    input logic          sleep,
    input logic          dout_en
);
    logic is_wr, is_rd;
    logic rd1_q, rd2_q, wr1_q;

    assign is_wr = ce & ~sleep & (glob_wr | (byte_wr & |byte_en));
    assign is_rd = ce & ~sleep & ~is_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd1_q <= 1'b0;
            rd2_q <= 1'b0;
            wr1_q <= 1'b0;
        end else begin
            rd1_q <= is_rd;
            rd2_q <= rd1_q;
            wr1_q <= is_wr;
        end
    end

    a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !dout_en);
    a_r11_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_en);
    a_r10_write_off: assert property (@(posedge clk) disable iff (!rst_n)
        wr1_q |-> !dout_en);
    a_r3_pipe_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !rd2_q) |-> !dout_en);
    a_r3_pipe_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && rd2_q && !wr1_q && oe && !sleep) |-> dout_en);
    a_r4_ft_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && !rd1_q && !rd2_q) |-> !dout_en);
    a_r2_ft_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && rd1_q && oe && !sleep) |-> dout_en);
endmodule

bind sram_sync_core sram_sync_core_chk #(.NB(NB)) u_chk (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce(ce),
    .byte_en(byte_en), .byte_wr(byte_wr), .glob_wr(glob_wr),
    .oe(oe), .sleep(sleep), .dout_en(dout_en)
);

// File: tb/sram_sync_core_bench.sv
module sram_sync_core_bench;
    localparam int DEPTH = 64;
    localparam int W     = 36;
    localparam int NB    = 4;
    localparam int AW    = 6;

    logic clk = 1'b0;
    logic rst_n, pipe_mode, ce, byte_wr, glob_wr, oe, sleep;
    logic [AW-1:0] addr;
    logic [W-1:0]  din;
    logic [NB-1:0] byte_en;
    logic [W-1:0]  dout;
    logic          dout_en;

    logic [W-1:0] ref_mem [DEPTH];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sram_sync_core #(.DEPTH(DEPTH), .WIDTH(W)) u_sram_sync_core (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce(ce),
        .addr(addr), .din(din), .byte_en(byte_en), .byte_wr(byte_wr),
        .glob_wr(glob_wr), .oe(oe), .sleep(sleep), .dout(dout),
        .dout_en(dout_en)
    );

    function automatic logic [W-1:0] pat(input int a, input int salt);
        return (W'(a + 1) * 36'h0_2468_ACE1) ^ (W'(salt) * 36'h5_A5A5_A5A5);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_en(input string req, input logic exp);
        checks++;
        if (dout_en !== exp) begin
            fails++;
            $display("FAIL %s: dout_en actual %b expected %b", req, dout_en, exp);
        end
    endtask

    task automatic chk_data(input string req, input logic [W-1:0] exp);
        checks++;
        if (dout_en !== 1'b1 || dout !== exp) begin
            fails++;
            $display("FAIL %s: dout actual %h (en %b) expected %h (en 1)",
                     req, dout, dout_en, exp);
        end
    endtask

    task automatic idle();
        ce = 1'b0; byte_wr = 1'b0; glob_wr = 1'b0; byte_en = '0;
    endtask

    task automatic issue_read(input int a);
        ce = 1'b1; byte_wr = 1'b0; glob_wr = 1'b0; byte_en = '0;
        addr = AW'(a);
    endtask

    task automatic issue_write(input int a, input logic [W-1:0] d,
                               input logic [NB-1:0] be, input logic bw,
                               input logic gw);
        ce = 1'b1; addr = AW'(a); din = d;
        byte_en = be; byte_wr = bw; glob_wr = gw;
    endtask

    // one flow-through read after the pipeline has emptied
    task automatic ft_read_check(input int a, input string req);
        pipe_mode = 1'b0;
        idle(); tick(); tick();
        issue_read(a); tick();
        chk_data(req, ref_mem[a]);
        idle(); tick();
    endtask

    task automatic t_fill();
        for (int a = 0; a < DEPTH; a++) begin
            issue_write(a, pat(a, 0), '0, 1'b0, 1'b1);
            tick();
            ref_mem[a] = pat(a, 0);
        end
        idle(); tick();
        chk_en("R10 idle after writes", 1'b0);
    endtask

    task automatic t_pipe_read();
        pipe_mode = 1'b1;
        idle(); tick(); tick();
        issue_read(7); tick();
        chk_en("R3 not yet driven after first edge", 1'b0);
        idle(); tick();
        chk_data("R3 pipelined data after second edge", ref_mem[7]);
        tick();
        chk_en("R4 pipelined driver off", 1'b0);
    endtask

    task automatic t_ft_read();
        pipe_mode = 1'b0;
        idle(); tick(); tick();
        issue_read(12); tick();
        chk_data("R2 flow-through data after first edge", ref_mem[12]);
        idle(); tick();
        chk_data("R4 flow-through held one cycle after deselect", ref_mem[12]);
        tick();
        chk_en("R4 flow-through driver off", 1'b0);
    endtask

    task automatic t_burst();
        pipe_mode = 1'b1;
        idle(); tick(); tick();
        for (int i = 0; i < 5; i++) begin
            issue_read(20 + 3 * i); tick();
            if (i > 0) chk_data("R5 pipelined back-to-back", ref_mem[20 + 3 * (i - 1)]);
        end
        idle(); tick();
        chk_data("R5 pipelined last word", ref_mem[32]);
        pipe_mode = 1'b0;
        tick(); tick();
        for (int i = 0; i < 5; i++) begin
            issue_read(40 + i); tick();
            chk_data("R5 flow-through back-to-back", ref_mem[40 + i]);
        end
        idle(); tick(); tick();
    endtask

    task automatic t_bytes();
        logic [W-1:0] d;
        d = 36'hF_0F0F_0F0F;
        issue_write(5, d, 4'b0010, 1'b1, 1'b0); tick();
        ref_mem[5][17:9] = d[17:9];
        ft_read_check(5, "R6 only lane 1 updated");
        issue_write(6, 36'h1_2345_6789, 4'b0000, 1'b1, 1'b0); tick();
        idle(); tick();
        ft_read_check(6, "R7 lane mode with no enable leaves word");
        issue_write(8, 36'hA_BCDE_F012, 4'b0000, 1'b0, 1'b1); tick();
        ref_mem[8] = 36'hA_BCDE_F012;
        ft_read_check(8, "R8 global write with lanes off");
        issue_write(9, 36'h3_3C3C_C3C3, 4'b0001, 1'b1, 1'b1); tick();
        ref_mem[9] = 36'h3_3C3C_C3C3;
        ft_read_check(9, "R8 global write overrides lane enables");
    endtask

    task automatic t_oe();
        pipe_mode = 1'b0;
        idle(); tick(); tick();
        issue_read(3); tick();
        idle();
        oe = 1'b0; #1;
        chk_en("R9 oe low turns driver off without clock", 1'b0);
        oe = 1'b1; #1;
        chk_data("R9 oe high restores data", ref_mem[3]);
        tick(); tick();
    endtask

    task automatic t_write_off();
        pipe_mode = 1'b1;
        idle(); tick(); tick();
        issue_read(30); tick();
        issue_write(31, pat(31, 1), '0, 1'b0, 1'b1); tick();
        ref_mem[31] = pat(31, 1);
        chk_en("R10 pipelined write cycle off", 1'b0);
        pipe_mode = 1'b0;
        idle(); tick(); tick();
        issue_read(30); tick();
        issue_write(31, pat(31, 2), '0, 1'b0, 1'b1); tick();
        ref_mem[31] = pat(31, 2);
        chk_en("R10 flow-through write cycle off", 1'b0);
        ft_read_check(31, "R10 write after read stored");
    endtask

    task automatic t_sleep();
        pipe_mode = 1'b0;
        idle(); tick(); tick();
        issue_read(50); tick();
        sleep = 1'b1; #1;
        chk_en("R11 sleep turns driver off without clock", 1'b0);
        issue_write(50, pat(50, 9), '0, 1'b0, 1'b1); tick();
        issue_read(51); tick();
        idle();
        sleep = 1'b0; #1;
        chk_en("R11 read during sleep ignored", 1'b0);
        issue_read(50); tick();
        chk_data("R11 data kept, write ignored, resumes", ref_mem[50]);
        idle(); tick(); tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pipe_mode = 1'b1; oe = 1'b1; sleep = 1'b0;
        addr = '0; din = '0;
        idle();
        repeat (3) @(posedge clk);
        #1;
        chk_en("R1 off during reset", 1'b0);
        rst_n = 1'b1;
        tick();
        chk_en("R1 off after reset", 1'b0);
        t_fill();
        t_pipe_read();
        t_ft_read();
        t_burst();
        t_bytes();
        t_oe();
        t_write_off();
        t_sleep();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule